// File: doc/BRIEF.md
# NAND Flash Page Controller

This block sits on the host side of a small-page, 8-bit NAND device and turns one request into the full bus sequence that the device expects. The host gives an operation code, a 24-bit byte address and a start pulse. The controller then drives chip enable, the command and address latch strobes, the write and read strobes and the output byte bus. It watches the ready/busy line and ends the request with a done pulse, the status byte and two error flags.

Page data moves over two byte streams that use a valid/ready handshake. One stream carries bytes from the host into a page program. The other carries bytes out to the host during a page read. Bus timing comes from parameters given in clock cycles: the low and high widths of the write strobe, the low and high widths of the read strobe, and the access time before a read byte is sampled. A settle delay after the last write strobe gives the device time to pull busy low before the controller looks at it. A busy timeout ends a hung operation with a device reset.

Top module: `nand_page_ctrl`

## Requirements
- R1: A page read (op 0) starts with command 00h when address bit 8 is 0 and 01h when it is 1. The command is latched with the command strobe high, and three address cycles follow with the address strobe high.
- R2: The first address byte is address bits 7..0. The second is bits 16..9. The third is bit 7 driven low over bits 23..17 in bits 6..0.
- R3: A page program (op 1) issues 80h, the three address cycles, then PAGE_BYTES data cycles taken in order from the write stream, then 10h.
- R4: A block erase (op 2) issues 60h, only the second and third address cycles, then D0h.
- R5: After the program confirm or the erase confirm, the controller waits for ready/busy high. It then issues 70h and reads one byte. reqStatus returns that byte, and reqFail is set exactly when bit 0 of the byte is 1.
- R6: A status request (op 3) issues 70h, reads one byte and returns it on reqStatus with reqFail clear. It does not wait on ready/busy.
- R7: A page read waits for ready/busy high, then streams PAGE_BYTES bytes in device order on rdData. rdValid stays high and rdData stays stable until rdReady accepts the byte.
- R8: The write strobe stays low for exactly WE_LOW_CYC clocks and high for at least WE_HIGH_CYC clocks between latches. The read strobe stays low for exactly max(RE_LOW_CYC, REA_CYC) clocks, and the data is sampled on its rising edge.
- R9: If ready/busy stays low for BUSY_TIMEOUT_CYC clocks after the settle delay, the controller issues FFh and ends the request with reqTimeout set.
- R10: Chip enable is low for the whole request and high while idle. reqReady is high only while idle, and a start pulse while not ready has no effect. The command and address strobes are never high together.
- R11: reqDone is a single-cycle pulse at the end of every request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqStart | input | 1 | Starts a request when reqReady is high |
| reqOp | input | 2 | 0 read, 1 program, 2 erase, 3 status |
| reqAddr | input | 24 | Byte address (column in bits 7..0, half select in bit 8, row in bits 23..9) |
| reqReady | output | 1 | Controller idle |
| reqDone | output | 1 | One-cycle end-of-request pulse |
| reqStatus | output | 8 | Status byte read from the device |
| reqFail | output | 1 | Program or erase failure (status bit 0) |
| reqTimeout | output | 1 | Busy wait timed out and a reset was issued |
| wrData | input | 8 | Program data byte |
| wrValid | input | 1 | Program data valid |
| wrReady | output | 1 | Program byte accepted this cycle |
| rdData | output | 8 | Read data byte |
| rdValid | output | 1 | Read data valid |
| rdReady | input | 1 | Host accepts read byte |
| nandCeN | output | 1 | Device chip enable, active low |
| nandCle | output | 1 | Command latch strobe |
| nandAle | output | 1 | Address latch strobe |
| nandWeN | output | 1 | Write strobe, active low |
| nandReN | output | 1 | Read strobe, active low |
| nandDout | output | 8 | Byte driven to the device |
| nandDoutEn | output | 1 | Output enable for nandDout |
| nandDin | input | 8 | Byte from the device |
| nandRb | input | 1 | Ready/busy, high when ready |

## Verification
The embedded properties check these rules on every cycle: the command and address strobes are never high together, a bus cycle is never launched while one is still in flight, chip enable stays high while idle, a held read byte stays unchanged until it is accepted, and the done pulse lasts one cycle. The order of command and address bytes, the split of the address into its three bytes, the erase skipping the column cycle, the measured strobe widths, the status-bit failure decode and the timeout ending in a reset are only visible in the scenarios. There, a device model records every latched byte and a scoreboard compares the record against the sequence computed from the requested operation.

// File: rtl/nfc_pkg.sv
package nfc_pkg;
  typedef enum logic [1:0] {
    OP_READ   = 2'd0,
    OP_PROG   = 2'd1,
    OP_ERASE  = 2'd2,
    OP_STATUS = 2'd3
  } nfcOp_e;

  // strobes from sequencer to bus timer
  typedef struct packed {
    logic       goWr;
    logic       goRd;
    logic       cle;
    logic       ale;
    logic [7:0] wByte;
  } busReq_t;

  localparam logic [7:0] CMD_READ_LO  = 8'h00;
  localparam logic [7:0] CMD_READ_HI  = 8'h01;
  localparam logic [7:0] CMD_PROG     = 8'h80;
  localparam logic [7:0] CMD_PROG_GO  = 8'h10;
  localparam logic [7:0] CMD_ERASE    = 8'h60;
  localparam logic [7:0] CMD_ERASE_GO = 8'hD0;
  localparam logic [7:0] CMD_STATUS   = 8'h70;
  localparam logic [7:0] CMD_RESET    = 8'hFF;
endpackage

// File: rtl/nfc_bus_timer.sv
module nfc_bus_timer
  import nfc_pkg::*;
#(
  parameter int WE_LOW_CYC  = 10,
  parameter int WE_HIGH_CYC = 5,
  parameter int RE_LOW_CYC  = 10,
  parameter int RE_HIGH_CYC = 5,
  parameter int REA_CYC     = 10
) (
  input  logic       clk,
  input  logic       rstN,
  input  busReq_t    busReq,
  output logic       cycDone,
  output logic [7:0] rdByte,
  output logic       nandCle,
  output logic       nandAle,
  output logic       nandWeN,
  output logic       nandReN,
  output logic [7:0] nandDout,
  output logic       nandDoutEn,
  input  logic [7:0] nandDin
);
  localparam int RD_LOW = (RE_LOW_CYC > REA_CYC) ? RE_LOW_CYC : REA_CYC;
  localparam int MAXW1  = (WE_LOW_CYC > WE_HIGH_CYC) ? WE_LOW_CYC : WE_HIGH_CYC;
  localparam int MAXW2  = (RD_LOW > RE_HIGH_CYC) ? RD_LOW : RE_HIGH_CYC;
  localparam int MAXW   = (MAXW1 > MAXW2) ? MAXW1 : MAXW2;
  localparam int CW     = $clog2(MAXW + 1);

  typedef enum logic [2:0] {PH_IDLE, PH_WLO, PH_WHI, PH_RLO, PH_RHI} phase_e;
  phase_e ph;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ph <= PH_IDLE; cnt <= '0; cycDone <= 1'b0; rdByte <= '0;
      nandCle <= 1'b0; nandAle <= 1'b0; nandWeN <= 1'b1; nandReN <= 1'b1;
      nandDout <= '0; nandDoutEn <= 1'b0;
    end else begin
      cycDone <= 1'b0;
      case (ph)
        PH_IDLE: begin
          if (busReq.goWr) begin
            ph <= PH_WLO; cnt <= CW'(WE_LOW_CYC - 1);
            nandWeN <= 1'b0; nandCle <= busReq.cle; nandAle <= busReq.ale;
            nandDout <= busReq.wByte; nandDoutEn <= 1'b1;
          end else if (busReq.goRd) begin
            ph <= PH_RLO; cnt <= CW'(RD_LOW - 1); nandReN <= 1'b0;
          end
        end
        PH_WLO: begin
          if (cnt == '0) begin
            ph <= PH_WHI; nandWeN <= 1'b1; cnt <= CW'(WE_HIGH_CYC - 1);
          end else cnt <= cnt - 1'b1;
        end
        PH_WHI: begin
          if (cnt == '0) begin
            ph <= PH_IDLE; nandCle <= 1'b0; nandAle <= 1'b0;
            nandDoutEn <= 1'b0; cycDone <= 1'b1;
          end else cnt <= cnt - 1'b1;
        end
        PH_RLO: begin
          if (cnt == '0) begin
            rdByte <= nandDin; nandReN <= 1'b1;
            ph <= PH_RHI; cnt <= CW'(RE_HIGH_CYC - 1);
          end else cnt <= cnt - 1'b1;
        end
        PH_RHI: begin
          if (cnt == '0) begin
            ph <= PH_IDLE; cycDone <= 1'b1;
          end else cnt <= cnt - 1'b1;
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

  // a new cycle may only be launched while the timer is idle
  assert_launch_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    (busReq.goWr || busReq.goRd) |-> (ph == PH_IDLE));

  assert_cle_ale_excl_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(nandCle && nandAle));
endmodule

// File: rtl/nfc_seq.sv
module nfc_seq
  import nfc_pkg::*;
#(
  parameter int PAGE_BYTES       = 528,
  parameter int SETTLE_CYC       = 4,
  parameter int BUSY_TIMEOUT_CYC = 750000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqStart,
  input  logic [1:0]  reqOp,
  input  logic [23:0] reqAddr,
  output logic        reqReady,
  output logic        reqDone,
  output logic [7:0]  reqStatus,
  output logic        reqFail,
  output logic        reqTimeout,
  input  logic [7:0]  wrData,
  input  logic        wrValid,
  output logic        wrReady,
  output logic        rdValid,
  input  logic        rdReady,
  output busReq_t     busReq,
  input  logic        cycDone,
  input  logic [7:0]  rdByte,
  input  logic        nandRb,
  output logic        nandCeN
);
  localparam int BCW  = $clog2(PAGE_BYTES + 1);
  localparam int WMAX = (SETTLE_CYC > BUSY_TIMEOUT_CYC) ? SETTLE_CYC : BUSY_TIMEOUT_CYC;
  localparam int WCW  = $clog2(WMAX + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_CMD1, S_ADDR, S_WDATA, S_CMD2, S_SETTLE, S_WAITRB,
    S_RDATA, S_STCMD, S_STRD, S_RSTCMD, S_DONE
  } state_e;

  state_e st;
  nfcOp_e op;
  logic [23:0] addr;
  logic launched;
  logic [1:0] addrIdx;
  logic [BCW-1:0] byteCnt;
  logic [WCW-1:0] waitCnt;
  logic [7:0] cmd1Byte, cmd2Byte, addrByte;

  always_comb begin
    case (op)
      OP_PROG:  cmd1Byte = CMD_PROG;
      OP_ERASE: cmd1Byte = CMD_ERASE;
      default:  cmd1Byte = addr[8] ? CMD_READ_HI : CMD_READ_LO;
    endcase
    cmd2Byte = (op == OP_ERASE) ? CMD_ERASE_GO : CMD_PROG_GO;
    case (addrIdx)
      2'd0:    addrByte = addr[7:0];
      2'd1:    addrByte = addr[16:9];
      default: addrByte = {1'b0, addr[23:17]};
    endcase
  end

  always_comb begin
    busReq  = '0;
    wrReady = 1'b0;
    case (st)
      S_CMD1:   begin busReq.goWr = !launched; busReq.cle = 1'b1; busReq.wByte = cmd1Byte; end
      S_ADDR:   begin busReq.goWr = !launched; busReq.ale = 1'b1; busReq.wByte = addrByte; end
      S_WDATA:  begin
        busReq.goWr = !launched && wrValid; busReq.wByte = wrData;
        wrReady = !launched && wrValid;
      end
      S_CMD2:   begin busReq.goWr = !launched; busReq.cle = 1'b1; busReq.wByte = cmd2Byte; end
      S_STCMD:  begin busReq.goWr = !launched; busReq.cle = 1'b1; busReq.wByte = CMD_STATUS; end
      S_RSTCMD: begin busReq.goWr = !launched; busReq.cle = 1'b1; busReq.wByte = CMD_RESET; end
      S_STRD:   busReq.goRd = !launched;
      S_RDATA:  busReq.goRd = !launched && !rdValid;
      default:  ;
    endcase
  end

  assign reqReady = (st == S_IDLE);
  assign reqDone  = (st == S_DONE);
  assign nandCeN  = (st == S_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st <= S_IDLE; op <= OP_READ; addr <= '0; launched <= 1'b0;
      addrIdx <= '0; byteCnt <= '0; waitCnt <= '0; rdValid <= 1'b0;
      reqStatus <= '0; reqFail <= 1'b0; reqTimeout <= 1'b0;
    end else begin
      if (busReq.goWr || busReq.goRd) launched <= 1'b1;
      if (cycDone) launched <= 1'b0;
      case (st)
        S_IDLE: if (reqStart) begin
          op <= nfcOp_e'(reqOp); addr <= reqAddr;
          reqStatus <= '0; reqFail <= 1'b0; reqTimeout <= 1'b0;
          st <= (nfcOp_e'(reqOp) == OP_STATUS) ? S_STCMD : S_CMD1;
        end
        S_CMD1: if (cycDone) begin
          st <= S_ADDR;
          addrIdx <= (op == OP_ERASE) ? 2'd1 : 2'd0;
        end
        S_ADDR: if (cycDone) begin
          if (addrIdx == 2'd2) begin
            byteCnt <= '0; waitCnt <= '0;
            case (op)
              OP_PROG:  st <= S_WDATA;
              OP_ERASE: st <= S_CMD2;
              default:  st <= S_SETTLE;
            endcase
          end else addrIdx <= addrIdx + 1'b1;
        end
        S_WDATA: if (cycDone) begin
          if (byteCnt == BCW'(PAGE_BYTES - 1)) st <= S_CMD2;
          else byteCnt <= byteCnt + 1'b1;
        end
        S_CMD2: if (cycDone) begin st <= S_SETTLE; waitCnt <= '0; end
        S_SETTLE: begin
          if (waitCnt == WCW'(SETTLE_CYC - 1)) begin st <= S_WAITRB; waitCnt <= '0; end
          else waitCnt <= waitCnt + 1'b1;
        end
        S_WAITRB: begin
          if (nandRb) begin
            st <= (op == OP_READ) ? S_RDATA : S_STCMD; byteCnt <= '0;
          end else if (waitCnt == WCW'(BUSY_TIMEOUT_CYC - 1)) st <= S_RSTCMD;
          else waitCnt <= waitCnt + 1'b1;
        end
        S_RDATA: begin
          if (cycDone) rdValid <= 1'b1;
          if (rdValid && rdReady) begin
            rdValid <= 1'b0;
            if (byteCnt == BCW'(PAGE_BYTES - 1)) st <= S_DONE;
            else byteCnt <= byteCnt + 1'b1;
          end
        end
        S_STCMD: if (cycDone) st <= S_STRD;
        S_STRD: if (cycDone) begin
          reqStatus <= rdByte;
          reqFail <= rdByte[0] && (op != OP_STATUS);
          st <= S_DONE;
        end
        S_RSTCMD: if (cycDone) begin reqTimeout <= 1'b1; st <= S_DONE; end
        S_DONE: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_rd_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && !rdReady) |=> (rdValid && $stable(rdByte)));

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rstN)
    reqDone |=> !reqDone);

  assert_ce_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (nandCeN && !busReq.goWr && !busReq.goRd));
endmodule

// File: rtl/nand_page_ctrl.sv
module nand_page_ctrl
  import nfc_pkg::*;
#(
  parameter int PAGE_BYTES       = 528,
  parameter int WE_LOW_CYC       = 10,
  parameter int WE_HIGH_CYC      = 5,
  parameter int RE_LOW_CYC       = 10,
  parameter int RE_HIGH_CYC      = 5,
  parameter int REA_CYC          = 10,
  parameter int SETTLE_CYC       = 4,
  parameter int BUSY_TIMEOUT_CYC = 750000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqStart,
  input  logic [1:0]  reqOp,
  input  logic [23:0] reqAddr,
  output logic        reqReady,
  output logic        reqDone,
  output logic [7:0]  reqStatus,
  output logic        reqFail,
  output logic        reqTimeout,
  input  logic [7:0]  wrData,
  input  logic        wrValid,
  output logic        wrReady,
  output logic [7:0]  rdData,
  output logic        rdValid,
  input  logic        rdReady,
  output logic        nandCeN,
  output logic        nandCle,
  output logic        nandAle,
  output logic        nandWeN,
  output logic        nandReN,
  output logic [7:0]  nandDout,
  output logic        nandDoutEn,
  input  logic [7:0]  nandDin,
  input  logic        nandRb
);
  busReq_t busReq;
  logic cycDone;

  nfc_seq #(
    .PAGE_BYTES(PAGE_BYTES), .SETTLE_CYC(SETTLE_CYC),
    .BUSY_TIMEOUT_CYC(BUSY_TIMEOUT_CYC)
  ) u_seq (
    .clk(clk), .rstN(rstN), .reqStart(reqStart), .reqOp(reqOp), .reqAddr(reqAddr),
    .reqReady(reqReady), .reqDone(reqDone), .reqStatus(reqStatus), .reqFail(reqFail),
    .reqTimeout(reqTimeout), .wrData(wrData), .wrValid(wrValid), .wrReady(wrReady),
    .rdValid(rdValid), .rdReady(rdReady), .busReq(busReq), .cycDone(cycDone),
    .rdByte(rdData), .nandRb(nandRb), .nandCeN(nandCeN)
  );

  nfc_bus_timer #(
    .WE_LOW_CYC(WE_LOW_CYC), .WE_HIGH_CYC(WE_HIGH_CYC), .RE_LOW_CYC(RE_LOW_CYC),
    .RE_HIGH_CYC(RE_HIGH_CYC), .REA_CYC(REA_CYC)
  ) u_timer (
    .clk(clk), .rstN(rstN), .busReq(busReq), .cycDone(cycDone), .rdByte(rdData),
    .nandCle(nandCle), .nandAle(nandAle), .nandWeN(nandWeN), .nandReN(nandReN),
    .nandDout(nandDout), .nandDoutEn(nandDoutEn), .nandDin(nandDin)
  );
endmodule

// File: tb/sim_nand_page_ctrl.sv
`timescale 1ns/1ps
module sim_nand_page_ctrl;
  localparam int PAGE = 528;
  localparam int WLO = 10, WHI = 5, RLO = 10;
  localparam real CYC = 4.0;

  logic clk = 1'b0, rstN = 1'b0;
  logic reqStart = 1'b0;
  logic [1:0] reqOp = 2'd0;
  logic [23:0] reqAddr = '0;
  logic reqReady, reqDone, reqFail, reqTimeout, wrReady, rdValid;
  logic [7:0] reqStatus, rdData, nandDout;
  logic [7:0] wrData = '0;
  logic wrValid = 1'b0, rdReady = 1'b0;
  logic nandCeN, nandCle, nandAle, nandWeN, nandReN, nandDoutEn;
  logic [7:0] nandDin = '0;
  logic nandRb = 1'b1;

  int nChecks = 0, nFails = 0;
  logic [9:0] expQ[$];
  logic [7:0] statusVal = 8'hC0;
  bit statusMode = 0, stuck = 0, pendRead = 0;
  int addrSeen = 0, readIdx = 0;
  realtime weFall, reFall, weRise;
  logic [7:0] gotStat; logic gotFail, gotTout;

  always #2 clk = ~clk;

  nand_page_ctrl #(.BUSY_TIMEOUT_CYC(3000)) u0 (
    .clk(clk), .rstN(rstN), .reqStart(reqStart), .reqOp(reqOp), .reqAddr(reqAddr),
    .reqReady(reqReady), .reqDone(reqDone), .reqStatus(reqStatus), .reqFail(reqFail),
    .reqTimeout(reqTimeout), .wrData(wrData), .wrValid(wrValid), .wrReady(wrReady),
    .rdData(rdData), .rdValid(rdValid), .rdReady(rdReady), .nandCeN(nandCeN),
    .nandCle(nandCle), .nandAle(nandAle), .nandWeN(nandWeN), .nandReN(nandReN),
    .nandDout(nandDout), .nandDoutEn(nandDoutEn), .nandDin(nandDin), .nandRb(nandRb)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int i);
    return 8'(i) ^ 8'h5A;
  endfunction

  // ---------------- device model + scoreboard monitor ----------------
  task automatic goBusy(input realtime dur);
    fork
      begin
        #5 nandRb = 1'b0;
        if (!stuck) begin #(dur) nandRb = 1'b1; end
      end
    join_none
  endtask

  always @(negedge nandWeN) if (rstN) weFall = $realtime;
  always @(negedge nandReN) if (rstN) begin
    reFall = $realtime;
    #21;
    nandDin = statusMode ? statusVal : pat(readIdx);
    if (!statusMode) readIdx++;
  end
  always @(posedge nandReN) if (rstN)
    chk(($realtime - reFall) == RLO * CYC, "R8", "RE low ns", 32'($realtime - reFall), 32'(RLO * CYC));

  always @(posedge nandWeN) if (rstN) begin
    logic [9:0] got;
    got = {nandCle, nandAle, nandDout};
    chk(($realtime - weFall) == WLO * CYC, "R8", "WE low ns", 32'($realtime - weFall), 32'(WLO * CYC));
    chk(!nandCeN && nandDoutEn, "R10", "CE/OE during latch", {nandCeN, nandDoutEn}, 2'b01);
    if (expQ.size() == 0) chk(0, "R1", "unexpected latch", got, 0);
    else begin
      logic [9:0] e;
      e = expQ.pop_front();
      chk(got == e, "R1", "latched item {cle,ale,byte}", got, e);
    end
    weRise = $realtime;
    if (nandCle) begin
      case (nandDout)
        8'h70: statusMode = 1;
        8'h00, 8'h01: begin statusMode = 0; pendRead = 1; addrSeen = 0; end
        8'h80, 8'h60: begin statusMode = 0; pendRead = 0; end
        8'h10: goBusy(2000);
        8'hD0: goBusy(4000);
        8'hFF: begin stuck = 0; nandRb = 1'b1; end
        default: ;
      endcase
    end else if (nandAle && pendRead) begin
      addrSeen++;
      if (addrSeen == 3) begin pendRead = 0; readIdx = 0; goBusy(400); end
    end
  end
  always @(negedge nandWeN) if (rstN && weRise > 0)
    chk(($realtime - weRise) >= WHI * CYC, "R8", "WE high ns", 32'($realtime - weRise), 32'(WHI * CYC));

  // ---------------- driver side ----------------
  task automatic pushCmd(input logic [7:0] b); expQ.push_back({2'b10, b}); endtask
  task automatic pushAdr(input logic [7:0] b); expQ.push_back({2'b01, b}); endtask
  task automatic pushRows(input logic [23:0] a);
    pushAdr(a[16:9]); pushAdr({1'b0, a[23:17]});
  endtask

  task automatic runOp(input logic [1:0] op, input logic [23:0] a);
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqOp = op; reqAddr = a; reqStart = 1'b1;
    @(negedge clk); reqStart = 1'b0;
    chk(!reqReady && !nandCeN, "R10", "busy during request", {reqReady, nandCeN}, 0);
    while (!reqDone) @(negedge clk);
    gotStat = reqStatus; gotFail = reqFail; gotTout = reqTimeout;
    @(negedge clk);
    chk(!reqDone, "R11", "done one cycle", reqDone, 0);
    chk(reqReady && nandCeN, "R10", "idle after request", {reqReady, nandCeN}, 2'b11);
  endtask

  task automatic feed(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wrValid = 1'b1; wrData = 8'(i * 7 + 3);
      #1;
      while (!wrReady) begin @(negedge clk); #1; end
    end
    @(negedge clk); wrValid = 1'b0;
  endtask

  task automatic sink(input int n);
    int idx = 0, k = 0;
    while (idx < n) begin
      @(negedge clk);
      rdReady = (k % 3) != 0; k++;
      if (rdValid && rdReady) begin
        chk(rdData == pat(idx), "R7", "read byte", rdData, pat(idx));
        idx++;
      end
    end
    @(negedge clk); rdReady = 1'b0;
  endtask

  initial begin
    #(CYC * 200000);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(nandCeN && nandWeN && nandReN && !nandCle && !nandAle && reqReady && !reqDone,
        "R10", "reset state", {nandCeN, nandWeN, nandReN, nandCle, nandAle, reqReady, reqDone},
        7'b1110010);
    rstN = 1'b1;

    // R6 status request
    statusVal = 8'hC1; pushCmd(8'h70);
    runOp(2'd3, 24'h0);
    chk(gotStat == 8'hC1 && !gotFail, "R6", "status op result", {gotStat, gotFail}, {8'hC1, 1'b0});
    chk(expQ.size() == 0, "R6", "status sequence complete", expQ.size(), 0);

    // R4 erase, R2 row bytes; a stray start while busy must be ignored (R10)
    statusVal = 8'hE0;
    pushCmd(8'h60); pushRows(24'hABCDEF); pushCmd(8'hD0); pushCmd(8'h70);
    fork
      runOp(2'd2, 24'hABCDEF);
      begin
        repeat (200) @(negedge clk);
        chk(!reqReady, "R10", "not ready mid erase", reqReady, 0);
        reqOp = 2'd3; reqStart = 1'b1; @(negedge clk); reqStart = 1'b0;
      end
    join
    chk(gotStat == 8'hE0 && !gotFail && !gotTout, "R5", "erase pass status",
        {gotStat, gotFail, gotTout}, {8'hE0, 2'b00});
    chk(expQ.size() == 0, "R4", "erase sequence complete", expQ.size(), 0);

    // R3 program with failing status, R5
    statusVal = 8'hE1;
    pushCmd(8'h80); pushAdr(8'h23); pushRows(24'h5A4123);
    for (int i = 0; i < PAGE; i++) expQ.push_back({2'b00, 8'(i * 7 + 3)});
    pushCmd(8'h10); pushCmd(8'h70);
    fork runOp(2'd1, 24'h5A4123); feed(PAGE); join
    chk(gotStat == 8'hE1 && gotFail, "R5", "program fail status", {gotStat, gotFail}, {8'hE1, 1'b1});
    chk(expQ.size() == 0, "R3", "program sequence complete", expQ.size(), 0);

    // R1 read, lower half (bit 8 = 0) and upper half (bit 8 = 1)
    pushCmd(8'h00); pushAdr(8'h10); pushRows(24'h0C02_10);
    fork runOp(2'd0, 24'h0C0210); sink(PAGE); join
    chk(expQ.size() == 0, "R1", "read lo sequence complete", expQ.size(), 0);
    pushCmd(8'h01); pushAdr(8'h44); pushRows(24'h7FFF44);
    fork runOp(2'd0, 24'h7FFF44); sink(PAGE); join
    chk(expQ.size() == 0, "R2", "read hi sequence complete", expQ.size(), 0);
    chk(!rdValid, "R7", "no extra read byte", rdValid, 0);

    // R9 busy timeout on erase
    stuck = 1;
    pushCmd(8'h60); pushRows(24'h012345); pushCmd(8'hD0); pushCmd(8'hFF);
    runOp(2'd2, 24'h012345);
    chk(gotTout && !gotFail, "R9", "timeout flag", {gotTout, gotFail}, 2'b10);
    chk(expQ.size() == 0, "R9", "reset issued", expQ.size(), 0);

    // recovery after timeout
    statusVal = 8'hC0; pushCmd(8'h70);
    runOp(2'd3, 24'h0);
    chk(gotStat == 8'hC0 && !gotTout, "R6", "status after timeout", {gotStat, gotTout}, {8'hC0, 1'b0});

    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule